// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Force

This block turns time-base events into two PWM output levels, A and B. On each time-base tick it looks at the counter value, the count direction and the zero and period strobes. It then derives up to four events: zero, period, a compare-A match while counting up, and a compare-B match while counting up. Each output has its own 16-bit action word, and every event has a 2-bit field in that word that either leaves the output alone, drives it low, drives it high or toggles it.

Per output, an event-driven level machine has two states, `LVL_LOW` and `LVL_HIGH`, and moves between them on tick edges.
- Set moves either state to `LVL_HIGH`.
- Clear moves either state to `LVL_LOW`.
- Toggle swaps the state.
- No action, or no tick, keeps the state.

A continuous software force sits on top of this level. The force word written by software is a shadow. It is copied into an active force register only at a selectable reload point. While the active force for an output is low or high, that output shows the forced level. When the force is released, the output shows the event-driven level again. That level kept evolving while the force was applied.

The time base and the compare registers live outside this block and feed it directly.

Top module: `pwm_aq_core`

## Requirements
- R1: While `rst_n` is low, both outputs are low, the event-driven levels are low and the active force is disabled.
- R2: A 2-bit action field encodes 00 no action, 01 drive low, 10 drive high, 11 toggle. An action takes effect on the clock edge where `tick` is high, and the output shows it from that edge.
- R3: The zero event (`evt_zero` with `tick`) applies bits 1:0 of the output's action word. The period event (`evt_period` with `tick`) applies bits 3:2.
- R4: A compare-A event fires on a tick where `dir_up` is high and `cnt` equals `cmp_a`, and applies bits 5:4. No compare-A event fires while counting down.
- R5: A compare-B event fires on a tick where `dir_up` is high and `cnt` equals `cmp_b`, and applies bits 9:8.
- R6: When several events share a tick, only the highest-ranked event whose field is not 00 acts. The ranking from highest to lowest is compare B, compare A, period, zero.
- R7: The active force for A sits in bits 1:0 of the force word and the force for B in bits 3:2. In each, 01 forces low, 10 forces high, and 00 or 11 is disabled. An active force overrides every event action on its output.
- R8: `reload_sel` picks when the force word is copied to the active force, always on a tick: 00 on a zero event, 01 on a period event, 10 on either event, 11 on every tick. Changing the force word has no effect before its reload tick.
- R9: Releasing the force returns the output to its event-driven level, including changes made by events while the force was applied.
- R10: On a clock edge without `tick`, neither output changes, whatever the event strobes and force word are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base tick enable |
| dir_up | input | 1 | Counter is counting up |
| evt_zero | input | 1 | Counter at zero (valid with tick) |
| evt_period | input | 1 | Counter at period (valid with tick) |
| cnt | input | 16 | Time-base counter value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| ctl_a | input | 16 | Action word for output A |
| ctl_b | input | 16 | Action word for output B |
| force_sw | input | 4 | Shadow continuous-force word |
| reload_sel | input | 2 | Force reload point select |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Action words are tried with set, clear and toggle on single events. Repeated zero events tell a set apart from a toggle. Compare matches are driven in both count directions, which shows that direction gates compare events but not zero or period events. Coincident zero and compare ticks, with different fields left empty, show both the ranking and the rule that an empty field never masks a lower-ranked event. Force words are changed between ticks of the wrong kind and then of the right kind for each reload select. The output is then released, which shows that the hidden event level kept following events while it was overridden.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    // Field offsets inside an action word
    localparam int FLD_ZERO = 0;
    localparam int FLD_PRD  = 2;
    localparam int FLD_CMPA = 4;
    localparam int FLD_CMPB = 8;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF     = 2'b00,
        FRC_LOW     = 2'b01,
        FRC_HIGH    = 2'b10,
        FRC_OFF_ALT = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic zero;
        logic prd;
        logic cmpa;
        logic cmpb;
    } evt_s;

endpackage

// File: rtl/pwm_aq_events.sv
module pwm_aq_events
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic             dir_up,
    input  logic             ev_zero_i,
    input  logic             ev_prd_i,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_s             evt
);

    always_comb begin
        evt.zero = tick & ev_zero_i;
        evt.prd  = tick & ev_prd_i;
        evt.cmpa = tick & dir_up & (cnt == cmp_a);
        evt.cmpb = tick & dir_up & (cnt == cmp_b);
    end

endmodule

// File: rtl/pwm_aq_force_shadow.sv
module pwm_aq_force_shadow
    import pwm_aq_pkg::*;
#(
    parameter int NCH = 2,
    localparam int FW = 2 * NCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ev_zero,
    input  logic          ev_prd,
    input  logic [FW-1:0] force_sw,
    input  rld_e          sel,
    output logic [FW-1:0] force_act
);

    logic          load;
    logic [FW-1:0] act_q;

    always_comb begin
        unique case (sel)
            RLD_ZERO:   load = tick & ev_zero;
            RLD_PERIOD: load = tick & ev_prd;
            RLD_EITHER: load = tick & (ev_zero | ev_prd);
            RLD_NOW:    load = tick;
            default:    load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= force_sw;
        end
    end

    assign force_act = act_q;

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_s             evt,
    input  logic [CTL_W-1:0] ctl,
    input  frc_e             frc,
    output logic             pwm,
    output logic             lvl_o
);

    act_e act_sel;
    lvl_e lvl_q, lvl_d;

    // Ranking: lowest first, later non-empty field overrides
    always_comb begin
        act_sel = ACT_NONE;
        if (evt.zero && (ctl[FLD_ZERO +: 2] != 2'b00)) act_sel = act_e'(ctl[FLD_ZERO +: 2]);
        if (evt.prd  && (ctl[FLD_PRD  +: 2] != 2'b00)) act_sel = act_e'(ctl[FLD_PRD  +: 2]);
        if (evt.cmpa && (ctl[FLD_CMPA +: 2] != 2'b00)) act_sel = act_e'(ctl[FLD_CMPA +: 2]);
        if (evt.cmpb && (ctl[FLD_CMPB +: 2] != 2'b00)) act_sel = act_e'(ctl[FLD_CMPB +: 2]);
    end

    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW: begin
                if (act_sel == ACT_HIGH || act_sel == ACT_TOGGLE) lvl_d = LVL_HIGH;
            end
            LVL_HIGH: begin
                if (act_sel == ACT_LOW || act_sel == ACT_TOGGLE) lvl_d = LVL_LOW;
            end
            default: lvl_d = LVL_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // Output process: force overrides event level
    always_comb begin
        unique case (frc)
            FRC_LOW:  pwm = 1'b0;
            FRC_HIGH: pwm = 1'b1;
            default:  pwm = lvl_q;
        endcase
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/pwm_aq_core.sv
module pwm_aq_core
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dir_up,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CTL_W-1:0] ctl_a,
    input  logic [CTL_W-1:0] ctl_b,
    input  logic [3:0]       force_sw,
    input  logic [1:0]       reload_sel,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int NCH = 2;
    localparam int FW  = 2 * NCH;

    evt_s             evt;
    logic [FW-1:0]    force_act;
    logic [CTL_W-1:0] ctl_v [NCH];
    logic [NCH-1:0]   pwm_v;
    logic [NCH-1:0]   lvl_v;

    assign ctl_v[0] = ctl_a;
    assign ctl_v[1] = ctl_b;

    pwm_aq_events #(.CNT_W(CNT_W)) u_events (
        .tick      (tick),
        .dir_up    (dir_up),
        .ev_zero_i (evt_zero),
        .ev_prd_i  (evt_period),
        .cnt       (cnt),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .evt       (evt)
    );

    pwm_aq_force_shadow #(.NCH(NCH)) u_force (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ev_zero   (evt_zero),
        .ev_prd    (evt_period),
        .force_sw  (force_sw),
        .sel       (rld_e'(reload_sel)),
        .force_act (force_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_aq_channel #(.CTL_W(CTL_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt),
            .ctl   (ctl_v[i]),
            .frc   (frc_e'(force_act[2*i +: 2])),
            .pwm   (pwm_v[i]),
            .lvl_o (lvl_v[i])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

endmodule

// File: rtl/pwm_aq_core_checker.sv
module pwm_aq_core_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        dir_up,
    input logic        evt_zero,
    input logic        evt_period,
    input logic [15:0] cnt,
    input logic [15:0] cmp_a,
    input logic [15:0] cmp_b,
    input logic [15:0] ctl_a,
    input logic [3:0]  force_sw,
    input logic [1:0]  reload_sel,
    input logic        pwm_a,
    input logic        pwm_b,
    input logic        lvl_a
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!pwm_a && !pwm_b && !lvl_a);
        end
    end

    property p_no_tick_hold;
        @(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b));
    endproperty
    assert_no_tick_hold_R10: assert property (p_no_tick_hold);

    property p_force_now_high;
        @(posedge clk) disable iff (!rst_n)
        (tick && reload_sel == 2'b11 && force_sw[1:0] == 2'b10) |=> pwm_a;
    endproperty
    assert_force_now_high_R8: assert property (p_force_now_high);

    property p_force_now_low_b;
        @(posedge clk) disable iff (!rst_n)
        (tick && reload_sel == 2'b11 && force_sw[3:2] == 2'b01) |=> !pwm_b;
    endproperty
    assert_force_now_low_b_R7: assert property (p_force_now_low_b);

    property p_cmpa_set;
        @(posedge clk) disable iff (!rst_n)
        (tick && dir_up && cnt == cmp_a && ctl_a[5:4] == 2'b10 &&
         (cnt != cmp_b || ctl_a[9:8] == 2'b00)) |=> lvl_a;
    endproperty
    assert_cmpa_set_R6: assert property (p_cmpa_set);

    property p_zero_toggle;
        @(posedge clk) disable iff (!rst_n)
        (tick && evt_zero && !evt_period && ctl_a[1:0] == 2'b11 &&
         !(dir_up && (cnt == cmp_a || cnt == cmp_b))) |=> (lvl_a != $past(lvl_a));
    endproperty
    assert_zero_toggle_R3: assert property (p_zero_toggle);

endmodule

bind pwm_aq_core pwm_aq_core_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .dir_up     (dir_up),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .cnt        (cnt),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .ctl_a      (ctl_a),
    .force_sw   (force_sw),
    .reload_sel (reload_sel),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .lvl_a      (lvl_v[0])
);

// File: tb/pwm_aq_core_tb_top.sv
module pwm_aq_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        dir_up = 1'b1;
    logic        evt_zero = 1'b0;
    logic        evt_period = 1'b0;
    logic [15:0] cnt = '0;
    logic [15:0] cmp_a = '0;
    logic [15:0] cmp_b = '0;
    logic [15:0] ctl_a = '0;
    logic [15:0] ctl_b = '0;
    logic [3:0]  force_sw = '0;
    logic [1:0]  reload_sel = '0;
    logic        pwm_a;
    logic        pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_aq_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .dir_up     (dir_up),
        .evt_zero   (evt_zero),
        .evt_period (evt_period),
        .cnt        (cnt),
        .cmp_a      (cmp_a),
        .cmp_b      (cmp_b),
        .ctl_a      (ctl_a),
        .ctl_b      (ctl_b),
        .force_sw   (force_sw),
        .reload_sel (reload_sel),
        .pwm_a      (pwm_a),
        .pwm_b      (pwm_b)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 0; evt_zero = 0; evt_period = 0; dir_up = 1; cnt = '0;
        cmp_a = 16'd1000; cmp_b = 16'd2000; ctl_a = '0; ctl_b = '0;
        force_sw = '0; reload_sel = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle with tick high, outputs sampled at the following falling edge
    task automatic pulse(input logic t, input logic z, input logic p, input logic [15:0] c, input logic up);
        @(negedge clk);
        tick = t; evt_zero = z; evt_period = p; cnt = c; dir_up = up;
        @(negedge clk);
        tick = 0; evt_zero = 0; evt_period = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(pwm_a, 1'b0, "R1", "pwm_a in reset");
        check(pwm_b, 1'b0, "R1", "pwm_b in reset");
        do_reset();
        check(pwm_a, 1'b0, "R1", "pwm_a after reset");
    endtask

    task automatic t_zero_period();
        do_reset();
        ctl_a = 16'h0006;   // zero set, period clear
        ctl_b = 16'h0003;   // zero toggle
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R3", "A set on zero");
        check(pwm_b, 1'b1, "R2", "B toggled high on zero");
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R2", "A set again stays high");
        check(pwm_b, 1'b0, "R2", "B toggled low on zero");
        pulse(1, 0, 1, 16'd50, 1);
        check(pwm_a, 1'b0, "R3", "A cleared on period");
        check(pwm_b, 1'b0, "R2", "B no action on period");
    endtask

    task automatic t_no_tick();
        do_reset();
        ctl_a = 16'h0002;
        force_sw = 4'b1010;
        reload_sel = 2'b11;
        pulse(0, 1, 1, 16'd0, 1);
        check(pwm_a, 1'b0, "R10", "A ignores events without tick");
        check(pwm_b, 1'b0, "R10", "B ignores force without tick");
    endtask

    task automatic t_compare();
        do_reset();
        cmp_a = 16'd30; cmp_b = 16'd40;
        ctl_a = 16'h0020;   // compare-A set
        ctl_b = 16'h0200;   // compare-B set
        pulse(1, 0, 0, 16'd30, 1);
        check(pwm_a, 1'b1, "R4", "A set on compare-A up");
        check(pwm_b, 1'b0, "R5", "B unaffected by compare-A");
        ctl_a = 16'h0010;   // compare-A clear
        pulse(1, 0, 0, 16'd30, 0);
        check(pwm_a, 1'b1, "R4", "no compare-A event counting down");
        pulse(1, 0, 0, 16'd30, 1);
        check(pwm_a, 1'b0, "R4", "A cleared on compare-A up");
        pulse(1, 0, 0, 16'd40, 1);
        check(pwm_b, 1'b1, "R5", "B set on compare-B up");
    endtask

    task automatic t_priority();
        do_reset();
        cmp_a = 16'd0; cmp_b = 16'd500;
        ctl_a = 16'h001A;   // zero set, period set, compare-A clear
        pulse(1, 0, 1, 16'd99, 1);
        check(pwm_a, 1'b1, "R6", "period set");
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b0, "R6", "compare-A outranks zero");
        cmp_b = 16'd0;
        ctl_a = 16'h021A;   // plus compare-B set
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R6", "compare-B outranks compare-A");
        ctl_a = 16'h0001;   // only zero clear, others empty
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b0, "R6", "empty higher fields do not mask zero");
    endtask

    task automatic t_force();
        do_reset();
        ctl_a = 16'h0003;   // zero toggle
        ctl_b = 16'h0002;   // zero set
        reload_sel = 2'b00;
        force_sw = 4'b0110; // A high, B low
        pulse(1, 0, 1, 16'd5, 1);
        check(pwm_a, 1'b0, "R8", "A force not loaded on period");
        check(pwm_b, 1'b0, "R8", "B force not loaded on period");
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R7", "A forced high");
        check(pwm_b, 1'b0, "R7", "B forced low over set");
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R7", "A held high over toggle");
        force_sw = 4'b1100; // A disabled, B disabled (11)
        reload_sel = 2'b11;
        pulse(1, 0, 0, 16'd7, 1);
        check(pwm_a, 1'b0, "R9", "A returns to event level");
        check(pwm_b, 1'b1, "R9", "B returns to event level");
        // period reload
        reload_sel = 2'b01;
        force_sw = 4'b0001; // A low
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R8", "A not loaded on zero with period select");
        pulse(1, 0, 1, 16'd9, 1);
        check(pwm_a, 1'b0, "R8", "A forced low on period");
        // either reload
        reload_sel = 2'b10;
        force_sw = 4'b0010;
        pulse(1, 1, 0, 16'd0, 1);
        check(pwm_a, 1'b1, "R8", "A forced high on zero with either select");
        // immediate waits for a tick
        reload_sel = 2'b11;
        force_sw = 4'b0001;
        pulse(0, 0, 0, 16'd3, 1);
        check(pwm_a, 1'b1, "R8", "immediate force waits for tick");
        pulse(1, 0, 0, 16'd3, 1);
        check(pwm_a, 1'b0, "R8", "immediate force low on tick");
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_zero_period();
        t_no_tick();
        t_compare();
        t_priority();
        t_force();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule